// File: doc/BRIEF.md
# Serial Port Transmit/Receive FIFO Pair

This block holds the two byte queues that sit between a serial port's bit shifter and the processor bus. The bus side writes bytes into a transmit queue and reads bytes out of a receive queue. The shifter side takes bytes from the transmit queue and puts received bytes into the receive queue, each through a single-cycle strobe. Both queues are 16 entries deep and 8 bits wide.

Each queue has its own control word, which holds an enable, a flush action and a 6-bit trigger level. One packed status word reports the receive fill, the transmit fill and the transmit free space. Each direction raises a level-sensitive service request when its fill level is on the wrong side of its trigger. Software treats the transmit side as drained when the transmit fill field reads zero. It writes a new byte only when the free field is nonzero.

Register select (`bus_addr`): 0 = transmit control, 1 = receive control, 2 = status, 3 = data. Writing the data register pushes a transmit byte. Reading it with `bus_re` pops a receive byte.

Top module: `sfifo_pair`

## Requirements
- R1: After synchronous reset, both queues are empty and disabled, both control words read 0, the status word reads 0x1000_0000, and both requests are low.
- R2: In a control word, bit 0 is the enable and bits 13:8 are the trigger level, and both read back as written. Bit 1 requests a flush and always reads as 0. All other bits read 0.
- R3: The status word carries the receive fill in bits 5:0, the transmit fill in bits 13:8 and the transmit free count (16 minus the transmit fill) in bits 29:24. All other bits are 0.
- R4: Each queue delivers bytes in the order they were accepted. Reading the data register returns the oldest receive byte, or 0 when the receive queue is empty.
- R5: A push to a full queue and a pop from an empty queue are ignored, and the fill never exceeds 16.
- R6: An enabled receive push into a full queue raises `rx_ovf` for exactly the following cycle. A rejected push in consecutive cycles keeps it high.
- R7: A control write with bit 1 set empties that queue at the same clock edge. If the same write clears bit 0, the queue is left empty and disabled.
- R8: While a queue is disabled, pushes and pops to it are ignored and its contents are retained. `tx_avail` is low while the transmit queue is disabled.
- R9: `rx_req` is high exactly when the receive queue is enabled, its fill is nonzero, and its fill is at or above the trigger. A trigger of 1 therefore requests on a single byte.
- R10: `tx_req` is high exactly when the transmit queue is enabled and its fill is at or below the trigger.
- R11: `tx_avail` is high exactly when the transmit queue is enabled and not empty. `tx_data` then shows the oldest transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Read strobe; pops a receive byte when the data register is selected |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| tx_data | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit byte available to the shifter |
| tx_take | input | 1 | Shifter takes the oldest transmit byte |
| rx_data | input | 8 | Byte from the shifter |
| rx_put | input | 1 | Shifter pushes `rx_data` |
| rx_ovf | output | 1 | Receive overrun pulse |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |

## Verification
The assertions assume that every strobe is a clean single-cycle level sampled at the clock edge. They also assume that a pop strobe is only meaningful through the enable, and they make no assumption about how read and write strobes overlap. The stimulus keeps these inputs synchronous by driving them on the falling edge. It freely mixes shifter strobes with bus accesses in the same cycle, including pushes into a full queue and pops from an empty one. Trigger values range above the queue depth, so the requests meet both saturated and unreachable thresholds.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
    localparam int BUS_W         = 32;
    localparam int LVL_W         = 6;
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_FLUSH_BIT = 1;
    localparam int CTL_TRIG_LSB  = 8;
    localparam int ST_RXFILL_LSB = 0;
    localparam int ST_TXFILL_LSB = 8;
    localparam int ST_TXFREE_LSB = 24;

    typedef enum logic [1:0] {
        REG_TXCTL = 2'd0,
        REG_RXCTL = 2'd1,
        REG_STAT  = 2'd2,
        REG_DATA  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             en;
        logic [LVL_W-1:0] trig;
    } dir_ctl_t;

    function automatic dir_ctl_t unpack_ctl(input logic [BUS_W-1:0] w);
        dir_ctl_t c;
        c.en   = w[CTL_EN_BIT];
        c.trig = w[CTL_TRIG_LSB +: LVL_W];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] pack_ctl(input dir_ctl_t c);
        logic [BUS_W-1:0] r;
        r = '0;
        r[CTL_EN_BIT] = c.en;
        r[CTL_TRIG_LSB +: LVL_W] = c.trig;
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] pack_status(input logic [LVL_W-1:0] rx_fill,
                                                    input logic [LVL_W-1:0] tx_fill,
                                                    input logic [LVL_W-1:0] tx_free);
        logic [BUS_W-1:0] r;
        r = '0;
        r[ST_RXFILL_LSB +: LVL_W] = rx_fill;
        r[ST_TXFILL_LSB +: LVL_W] = tx_fill;
        r[ST_TXFREE_LSB +: LVL_W] = tx_free;
        return r;
    endfunction
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          push_rej
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, empty, do_push, do_pop;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (cnt == CW'(DEPTH));
    assign empty    = (cnt == '0);
    assign do_push  = push && !full && !flush;
    assign do_pop   = pop && !empty && !flush;
    assign push_rej = push && full && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= adv(wp);
            if (do_pop)  rp <= adv(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    assign dout  = mem[rp];
    assign count = cnt;
endmodule

// File: rtl/sfq_dirctl.sv
module sfq_dirctl
    import sfq_pkg::*;
#(
    parameter bit IS_RX = 1'b0,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [CW-1:0]    count,
    output dir_ctl_t         ctl,
    output logic             flush,
    output logic             req
);
    logic [LVL_W-1:0] lvl;

    always_ff @(posedge clk) begin
        if (rst)     ctl <= '0;
        else if (wr) ctl <= unpack_ctl(wdata);
    end

    assign flush = wr && wdata[CTL_FLUSH_BIT];
    assign lvl   = LVL_W'(count);

    generate
        if (IS_RX) begin : g_rx_req
            assign req = ctl.en && (lvl != '0) && (lvl >= ctl.trig);
        end else begin : g_tx_req
            assign req = ctl.en && (lvl <= ctl.trig);
        end
    endgenerate
endmodule

// File: rtl/sfifo_pair.sv
module sfifo_pair
    import sfq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic [DW-1:0]    tx_data,
    output logic             tx_avail,
    input  logic             tx_take,
    input  logic [DW-1:0]    rx_data,
    input  logic             rx_put,
    output logic             rx_ovf,
    output logic             tx_req,
    output logic             rx_req
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int DTX = 0;
    localparam int DRX = 1;

    reg_sel_e      sel;
    dir_ctl_t      ctl_q  [2];
    logic          wr_ctl [2];
    logic          flush  [2];
    logic          push   [2];
    logic          pop    [2];
    logic          rej    [2];
    logic          req    [2];
    logic [DW-1:0] din    [2];
    logic [DW-1:0] dout   [2];
    logic [CW-1:0] cnt    [2];

    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_en, rx_en;

    assign sel = reg_sel_e'(bus_addr);

    assign wr_ctl[DTX] = bus_we && (sel == REG_TXCTL);
    assign wr_ctl[DRX] = bus_we && (sel == REG_RXCTL);
    assign push[DTX]   = bus_we && (sel == REG_DATA) && ctl_q[DTX].en;
    assign din[DTX]    = bus_wdata[DW-1:0];
    assign pop[DTX]    = tx_take && ctl_q[DTX].en;
    assign push[DRX]   = rx_put && ctl_q[DRX].en;
    assign din[DRX]    = rx_data;
    assign pop[DRX]    = bus_re && (sel == REG_DATA) && ctl_q[DRX].en;

    generate
        for (genvar d = 0; d < 2; d++) begin : g_dir
            sfq_dirctl #(.IS_RX(d == DRX), .CW(CW)) u_ctl (
                .clk   (clk),
                .rst   (rst),
                .wr    (wr_ctl[d]),
                .wdata (bus_wdata),
                .count (cnt[d]),
                .ctl   (ctl_q[d]),
                .flush (flush[d]),
                .req   (req[d])
            );
            sfq_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
                .clk      (clk),
                .rst      (rst),
                .flush    (flush[d]),
                .push     (push[d]),
                .din      (din[d]),
                .pop      (pop[d]),
                .dout     (dout[d]),
                .count    (cnt[d]),
                .push_rej (rej[d])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) rx_ovf <= 1'b0;
        else     rx_ovf <= rej[DRX];
    end

    assign tx_cnt   = cnt[DTX];
    assign rx_cnt   = cnt[DRX];
    assign tx_en    = ctl_q[DTX].en;
    assign rx_en    = ctl_q[DRX].en;
    assign tx_data  = dout[DTX];
    assign tx_avail = tx_en && (tx_cnt != '0);
    assign tx_req   = req[DTX];
    assign rx_req   = req[DRX];

    always_comb begin
        unique case (sel)
            REG_TXCTL: bus_rdata = pack_ctl(ctl_q[DTX]);
            REG_RXCTL: bus_rdata = pack_ctl(ctl_q[DRX]);
            REG_STAT:  bus_rdata = pack_status(LVL_W'(rx_cnt), LVL_W'(tx_cnt),
                                               LVL_W'(DEPTH) - LVL_W'(tx_cnt));
            default:   bus_rdata = (rx_cnt != '0) ? BUS_W'(dout[DRX]) : '0;
        endcase
    end
endmodule

// File: rtl/sfq_checker.sv
module sfq_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    bus_addr,
    input logic          bus_we,
    input logic [31:0]   bus_wdata,
    input logic          rx_put,
    input logic          rx_ovf,
    input logic          tx_req,
    input logic          rx_req,
    input logic          tx_avail,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic          tx_en,
    input logic          rx_en
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (tx_cnt == '0 && rx_cnt == '0 && !tx_en && !rx_en));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    a_r6_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        rx_ovf |-> ($past(rx_put) && $past(rx_en) && $past(rx_cnt) == CW'(DEPTH)));

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd1 && bus_wdata[1]) |=> (rx_cnt == '0));

    a_r8_disabled_holds: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !(bus_we && bus_addr == 2'd1)) |=> $stable(rx_cnt));

    a_r9_rx_req_nonempty: assert property (@(posedge clk) disable iff (rst)
        rx_req |-> (rx_en && rx_cnt != '0));

    a_r10_tx_req_enabled: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> tx_en);

    a_r11_avail_nonempty: assert property (@(posedge clk) disable iff (rst)
        tx_avail |-> (tx_en && tx_cnt != '0));
endmodule

bind sfifo_pair sfq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .rx_put    (rx_put),
    .rx_ovf    (rx_ovf),
    .tx_req    (tx_req),
    .rx_req    (rx_req),
    .tx_avail  (tx_avail),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt),
    .tx_en     (tx_en),
    .rx_en     (rx_en)
);

// File: tb/sfifo_pair_tb.sv
module sfifo_pair_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_avail;
    logic        tx_take = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_put = 1'b0;
    logic        rx_ovf, tx_req, rx_req;

    sfifo_pair u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data),
        .tx_avail(tx_avail), .tx_take(tx_take), .rx_data(rx_data), .rx_put(rx_put),
        .rx_ovf(rx_ovf), .tx_req(tx_req), .rx_req(rx_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    logic [7:0] tq[$];
    logic [7:0] rq[$];
    bit         ten = 0, ren = 0, exp_ovf = 0;
    logic [5:0] ttrig = '0, rtrig = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return 32'(rq.size()) | (32'(tq.size()) << 8) | (32'(DEPTH - tq.size()) << 24);
    endfunction
    function automatic logic [31:0] exp_ctl(input bit en, input logic [5:0] trig);
        return 32'(en) | (32'(trig) << 8);
    endfunction
    function automatic bit exp_rxreq();
        return ren && rq.size() != 0 && rq.size() >= int'(rtrig);
    endfunction
    function automatic bit exp_txreq();
        return ten && tq.size() <= int'(ttrig);
    endfunction

    task automatic out_checks();
        chk(rx_req == exp_rxreq(), "R9 rx_req", 32'(rx_req), 32'(exp_rxreq()));
        chk(tx_req == exp_txreq(), "R10 tx_req", 32'(tx_req), 32'(exp_txreq()));
        chk(tx_avail == (ten && tq.size() != 0), "R11 tx_avail", 32'(tx_avail), 32'(ten && tq.size() != 0));
        if (ten && tq.size() != 0)
            chk(tx_data == tq[0], "R4 tx_data order", 32'(tx_data), 32'(tq[0]));
        chk(rx_ovf == exp_ovf, "R6 rx_ovf", 32'(rx_ovf), 32'(exp_ovf));
    endtask

    // Entered on a falling edge; returns on the next falling edge.
    task automatic step(input bit we, input bit re, input logic [1:0] a, input logic [31:0] wd,
                        input bit put, input logic [7:0] pd, input bit take);
        bit tflush, rflush, tpush, tpop, rpush, rpop, rrej;
        out_checks();
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd;
        rx_put = put; rx_data = pd; tx_take = take;
        #1;
        if (a == 2'd2)
            chk(bus_rdata == exp_status(), "R3 status", bus_rdata, exp_status());
        else if (a == 2'd3)
            chk(bus_rdata == (rq.size() != 0 ? 32'(rq[0]) : 32'h0), "R4 rx read data",
                bus_rdata, rq.size() != 0 ? 32'(rq[0]) : 32'h0);
        else if (a == 2'd0)
            chk(bus_rdata == exp_ctl(ten, ttrig), "R2 tx ctl read", bus_rdata, exp_ctl(ten, ttrig));
        else
            chk(bus_rdata == exp_ctl(ren, rtrig), "R2 rx ctl read", bus_rdata, exp_ctl(ren, rtrig));
        tflush = we && a == 2'd0 && wd[1];
        rflush = we && a == 2'd1 && wd[1];
        tpush  = we && a == 2'd3 && ten && tq.size() < DEPTH;
        tpop   = take && ten && tq.size() > 0;
        rpush  = put && ren && rq.size() < DEPTH;
        rrej   = put && ren && rq.size() == DEPTH && !rflush;
        rpop   = re && a == 2'd3 && ren && rq.size() > 0;
        if (tpop) void'(tq.pop_front());
        if (tpush) tq.push_back(wd[7:0]);
        if (rpop) void'(rq.pop_front());
        if (rpush) rq.push_back(pd);
        if (tflush) tq.delete();
        if (rflush) rq.delete();
        exp_ovf = rrej;
        if (we && a == 2'd0) begin ten = wd[0]; ttrig = wd[13:8]; end
        if (we && a == 2'd1) begin ren = wd[0]; rtrig = wd[13:8]; end
        @(negedge clk);
        bus_we = 0; bus_re = 0; rx_put = 0; tx_take = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        peek(2'd2, v); chk(v == 32'h1000_0000, "R1 status after reset", v, 32'h1000_0000);
        peek(2'd0, v); chk(v == 32'h0, "R1 tx ctl after reset", v, 32'h0);
        peek(2'd1, v); chk(v == 32'h0, "R1 rx ctl after reset", v, 32'h0);
        chk(!tx_req && !rx_req, "R1 requests low", {tx_req, rx_req}, 0);
        // R2 enable, flush, trigger 1
        step(1, 0, 2'd0, 32'h0000_0103, 0, 0, 0);
        step(1, 0, 2'd1, 32'hFFFF_C0FD & 32'h0000_0101 | 32'h0000_0101, 0, 0, 0);
        step(0, 0, 2'd0, 0, 0, 0, 0);
        peek(2'd0, v); chk(v == 32'h0000_0101, "R2 flush reads zero", v, 32'h0000_0101);
        // R9 single byte with trigger 1
        step(0, 0, 2'd1, 0, 1, 8'hA5, 0);
        chk(rx_req == 1'b1, "R9 trigger 1 single byte", 32'(rx_req), 1);
        // R6 fill and overrun
        for (int i = 1; i < DEPTH; i++) step(0, 0, 2'd2, 0, 1, 8'(i * 7), 0);
        step(0, 0, 2'd2, 0, 1, 8'hEE, 0);
        chk(rx_ovf == 1'b1, "R6 overrun pulse", 32'(rx_ovf), 1);
        step(0, 0, 2'd2, 0, 0, 0, 0);
        chk(rx_ovf == 1'b0, "R6 overrun single cycle", 32'(rx_ovf), 0);
        // R4 drain in order, then R5 pop empty
        for (int i = 0; i < DEPTH; i++) step(0, 1, 2'd3, 0, 0, 0, 0);
        step(0, 1, 2'd3, 0, 0, 0, 0);
        peek(2'd2, v); chk(v[5:0] == 6'd0, "R5 pop from empty ignored", v, 32'h0);
        // R5 transmit overfill
        for (int i = 0; i <= DEPTH; i++) step(1, 0, 2'd3, 32'(8'h30 + i), 0, 0, 0);
        peek(2'd2, v); chk(v == 32'h0000_1000, "R5 tx full free zero", v, 32'h0000_1000);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 2'd2, 0, 0, 0, 1);
        // R7 flush with disable
        for (int i = 0; i < 3; i++) step(1, 0, 2'd3, 32'(i + 1), 0, 0, 0);
        step(1, 0, 2'd0, 32'h0000_0002, 0, 0, 0);
        peek(2'd2, v); chk(v[13:8] == 6'd0, "R7 flush empties tx", v, 32'h0);
        peek(2'd0, v); chk(v == 32'h0, "R7 left disabled", v, 32'h0);
        // R8 disabled ignores writes and takes
        step(1, 0, 2'd3, 32'h55, 0, 0, 1);
        peek(2'd2, v); chk(v[13:8] == 6'd0 && !tx_avail, "R8 disabled tx ignores push", v, 32'h0);
        // R10 transmit trigger 2
        step(1, 0, 2'd0, 32'h0000_0201, 0, 0, 0);
        chk(tx_req == 1'b1, "R10 empty below trigger", 32'(tx_req), 1);
        for (int i = 0; i < 3; i++) step(1, 0, 2'd3, 32'(i), 0, 0, 0);
        chk(tx_req == 1'b0, "R10 above trigger", 32'(tx_req), 0);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit we, re;
            logic [1:0] a;
            logic [31:0] wd;
            r = int'($urandom % 100);
            we = 0; re = 0; wd = $urandom;
            a = 2'($urandom);
            if (r < 8) begin
                we = 1; a = 2'($urandom % 2);
                wd = (($urandom % 10) != 0 ? 32'h1 : 32'h0) |
                     (($urandom % 25) == 0 ? 32'h2 : 32'h0) |
                     (32'($urandom % 19) << 8);
            end else if (r < 40) begin
                we = 1; a = 2'd3;
            end else begin
                re = (a == 2'd3) && ($urandom % 2 == 1);
            end
            step(we, re, a, wd, ($urandom % 3) == 0, 8'($urandom), ($urandom % 3) == 0);
        end
        out_checks();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule